// File: doc/BRIEF.md
# Single-Cycle Multiply-Accumulate Unit

This block multiplies two 16-bit operands and combines the product with a 48-bit running accumulator. It does this in one clock cycle. A 3-bit operation select chooses one of seven variants. Three treat the operands as unsigned: plain multiply, multiply-add and multiply-subtract. Four treat them as two's complement: plain multiply, multiply-negate, multiply-add and multiply-subtract. The 16 bits above the 32-bit product act as guard bits, so that long sums of products keep their magnitude. The accumulator still wraps modulo 2^48.

The host asserts `go` for one cycle with the operands and the operation code. On the next rising edge, `acc_q` and `prod_q` show the result, so a new operation can be issued every cycle. A separate `acc_clr` strobe empties the accumulator. If `acc_clr` and `go` are high in the same cycle, the clear wins and the start is dropped.

Top module: `mac16_acc48`

## Requirements
- R1: While `rst_n` is low, `acc_q` and `prod_q` are zero.
- R2: Code 0 (unsigned multiply) sets `prod_q` to the unsigned product `a*b` and sets `acc_q` to that product zero-extended to 48 bits.
- R3: Code 1 (unsigned multiply-add) adds the zero-extended unsigned product to `acc_q` and sets `prod_q` to the product.
- R4: Code 2 (unsigned multiply-subtract) subtracts the zero-extended unsigned product from `acc_q` and sets `prod_q` to the product.
- R5: Code 3 (signed multiply) sets `prod_q` to the two's-complement product and sets `acc_q` to that product sign-extended to 48 bits.
- R6: Code 4 (signed multiply-negate) sets `acc_q` to the negated sign-extended signed product. `prod_q` takes the signed product before negation.
- R7: Code 5 (signed multiply-add) adds the sign-extended signed product to `acc_q` and sets `prod_q` to the product.
- R8: Code 6 (signed multiply-subtract) subtracts the sign-extended signed product from `acc_q` and sets `prod_q` to the product.
- R9: Code 7 with `go` high changes neither output.
- R10: `acc_clr` high sets `acc_q` to zero on the next edge and leaves `prod_q` unchanged, whether or not `go` is high in the same cycle.
- R11: With `go` and `acc_clr` both low, both outputs hold their values.
- R12: Accumulator arithmetic wraps modulo 2^48. For example, subtracting 1 from 0 gives 0xFFFF_FFFF_FFFF, and adding 1 to that gives 0.
- R13: Each operation's result is visible after exactly one rising edge. Back-to-back operations on consecutive cycles each take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start strobe for one operation |
| opnd_a | input | 16 | First multiplier operand |
| opnd_b | input | 16 | Second multiplier operand |
| op_sel | input | 3 | Operation code 0..7 |
| acc_clr | input | 1 | Accumulator clear strobe |
| acc_q | output | 48 | Accumulator |
| prod_q | output | 32 | Product of the last executed operation |

## Verification
The clear strobe and a start strobe can arrive in the same cycle. In that case the clear must empty the accumulator while the start leaves no trace: the product register keeps its old value. The random phase raises `acc_clr` in about one cycle in eight, independent of `go` and the operation code, so this collision occurs across every operation. Directed steps also force it just after a product has been loaded. The check compares the accumulator against zero and the product register against the value from the previous operation.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned OPND_W = 16;
  localparam int unsigned ACC_W  = 48;
  localparam int unsigned PROD_W = 2 * OPND_W;

  typedef enum logic [2:0] {
    OP_UMUL  = 3'd0,
    OP_UMAC  = 3'd1,
    OP_UMSUB = 3'd2,
    OP_SMUL  = 3'd3,
    OP_SNEG  = 3'd4,
    OP_SMAC  = 3'd5,
    OP_SMSUB = 3'd6,
    OP_NOP   = 3'd7
  } mac_op_e;

  // control word for one operation
  typedef struct packed {
    logic valid;     // code performs work
    logic sgn;       // operands are two's complement
    logic keep;      // base is current accumulator (else zero)
    logic sub;       // subtract the extended product from the base
  } mac_ctl_t;

  function automatic mac_ctl_t decode_op(input logic [2:0] code);
    mac_ctl_t c;
    c = '0;
    case (mac_op_e'(code))
      OP_UMUL:  c = '{valid: 1'b1, sgn: 1'b0, keep: 1'b0, sub: 1'b0};
      OP_UMAC:  c = '{valid: 1'b1, sgn: 1'b0, keep: 1'b1, sub: 1'b0};
      OP_UMSUB: c = '{valid: 1'b1, sgn: 1'b0, keep: 1'b1, sub: 1'b1};
      OP_SMUL:  c = '{valid: 1'b1, sgn: 1'b1, keep: 1'b0, sub: 1'b0};
      OP_SNEG:  c = '{valid: 1'b1, sgn: 1'b1, keep: 1'b0, sub: 1'b1};
      OP_SMAC:  c = '{valid: 1'b1, sgn: 1'b1, keep: 1'b1, sub: 1'b0};
      OP_SMSUB: c = '{valid: 1'b1, sgn: 1'b1, keep: 1'b1, sub: 1'b1};
      default:  c = '0;
    endcase
    return c;
  endfunction

  // combine base and extended product modulo 2^ACC_W
  function automatic logic [ACC_W-1:0] acc_combine(input logic [ACC_W-1:0] base,
                                                    input logic [ACC_W-1:0] term,
                                                    input logic             sub);
    return sub ? (base - term) : (base + term);
  endfunction
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [2:0] op_sel,
  output mac_ctl_t   ctl
);
  always_comb ctl = decode_op(op_sel);
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned A_W   = 16,
  parameter int unsigned B_W   = 16,
  parameter int unsigned ACC_W = 48
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  input  logic               sgn,
  output logic [A_W+B_W-1:0] prod,
  output logic [ACC_W-1:0]   prod_ext
);
  localparam int unsigned P_W   = A_W + B_W;
  localparam int unsigned GUARD = ACC_W - P_W;

  // one extra bit per operand turns a single signed multiplier into both kinds
  logic signed [A_W:0]   a_x;
  logic signed [B_W:0]   b_x;
  logic signed [P_W+1:0] full;

  assign a_x  = {sgn & a[A_W-1], a};
  assign b_x  = {sgn & b[B_W-1], b};
  assign full = a_x * b_x;
  assign prod = full[P_W-1:0];

  generate
    if (GUARD > 0) begin : g_guard
      assign prod_ext = {{GUARD{sgn & prod[P_W-1]}}, prod};
    end else begin : g_noguard
      assign prod_ext = prod[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned P_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_clear,
  input  logic             do_update,
  input  mac_ctl_t         ctl,
  input  logic [P_W-1:0]   prod,
  input  logic [ACC_W-1:0] prod_ext,
  output logic [ACC_W-1:0] acc_q,
  output logic [P_W-1:0]   prod_q
);
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] acc_nxt;

  assign base    = ctl.keep ? acc_q : '0;
  assign acc_nxt = acc_combine(base, prod_ext, ctl.sub);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      prod_q <= '0;
    end else if (do_clear) begin
      acc_q  <= '0;
    end else if (do_update) begin
      acc_q  <= acc_nxt;
      prod_q <= prod;
    end
  end
endmodule

// File: rtl/mac16_acc48.sv
module mac16_acc48
  import mac_pkg::*;
#(
  parameter int unsigned A_W   = OPND_W,
  parameter int unsigned B_W   = OPND_W,
  parameter int unsigned ACC_W = mac_pkg::ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [A_W-1:0]   opnd_a,
  input  logic [B_W-1:0]   opnd_b,
  input  logic [2:0]       op_sel,
  input  logic             acc_clr,
  output logic [ACC_W-1:0] acc_q,
  output logic [A_W+B_W-1:0] prod_q
);
  localparam int unsigned P_W = A_W + B_W;

  mac_ctl_t         ctl;
  logic [P_W-1:0]   prod;
  logic [ACC_W-1:0] prod_ext;

  // named events for the checker
  logic ev_clear;
  logic ev_update;
  logic ev_dropped;

  assign ev_clear   = acc_clr;
  assign ev_update  = go & ctl.valid & ~acc_clr;
  assign ev_dropped = go & acc_clr;

  mac_decode u_dec (
    .op_sel (op_sel),
    .ctl    (ctl)
  );

  mac_mult #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_mul (
    .a        (opnd_a),
    .b        (opnd_b),
    .sgn      (ctl.sgn),
    .prod     (prod),
    .prod_ext (prod_ext)
  );

  mac_accum #(.ACC_W(ACC_W), .P_W(P_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_clear  (ev_clear),
    .do_update (ev_update),
    .ctl       (ctl),
    .prod      (prod),
    .prod_ext  (prod_ext),
    .acc_q     (acc_q),
    .prod_q    (prod_q)
  );
endmodule

// File: rtl/mac16_acc48_chk.sv
module mac16_acc48_chk #(
  parameter int unsigned A_W   = 16,
  parameter int unsigned B_W   = 16,
  parameter int unsigned ACC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic [A_W-1:0]   opnd_a,
  input logic [B_W-1:0]   opnd_b,
  input logic [2:0]       op_sel,
  input logic             acc_clr,
  input logic [ACC_W-1:0] acc_q,
  input logic [A_W+B_W-1:0] prod_q,
  input logic             ev_clear,
  input logic             ev_update,
  input logic             ev_dropped
);
  localparam int unsigned P_W   = A_W + B_W;
  localparam int unsigned GUARD = ACC_W - P_W;

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (!rst_n -> (acc_q == '0 && prod_q == '0)));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_q == '0) && (prod_q == $past(prod_q)));

  // R10
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_clear && ev_update) && (ev_dropped -> !ev_update));

  // R9
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !acc_clr && op_sel == 3'd7) |=> $stable(acc_q) && $stable(prod_q));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !acc_clr) |=> $stable(acc_q) && $stable(prod_q));

  // R2
  umul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !acc_clr && op_sel == 3'd0) |=>
      (prod_q == (P_W'($past(opnd_a)) * P_W'($past(opnd_b)))) && (acc_q == ACC_W'(prod_q)));

  // R3
  umac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !acc_clr && op_sel == 3'd1) |=> acc_q == $past(acc_q) + ACC_W'(prod_q));

  // R7
  smac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !acc_clr && op_sel == 3'd5) |=>
      acc_q == $past(acc_q) + {{GUARD{prod_q[P_W-1]}}, prod_q});

  // R8
  smsub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !acc_clr && op_sel == 3'd6) |=>
      acc_q == $past(acc_q) - {{GUARD{prod_q[P_W-1]}}, prod_q});
endmodule

bind mac16_acc48 mac16_acc48_chk #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .go         (go),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .op_sel     (op_sel),
  .acc_clr    (acc_clr),
  .acc_q      (acc_q),
  .prod_q     (prod_q),
  .ev_clear   (ev_clear),
  .ev_update  (ev_update),
  .ev_dropped (ev_dropped)
);

// File: tb/mac16_acc48_tb.sv
module mac16_acc48_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [2:0]  op_sel = '0;
  logic        acc_clr = 1'b0;
  logic [47:0] acc_q;
  logic [31:0] prod_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [47:0] exp_acc  = '0;
  logic [31:0] exp_prod = '0;

  always #5 clk = ~clk;

  mac16_acc48 u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .op_sel(op_sel), .acc_clr(acc_clr), .acc_q(acc_q), .prod_q(prod_q)
  );

  // product as a bench-side integer calculation
  function automatic logic [31:0] ref_prod(input logic [15:0] a, input logic [15:0] b, input bit sgn);
    longint pa, pb;
    pa = sgn ? longint'($signed(a)) : longint'({48'b0, a});
    pb = sgn ? longint'($signed(b)) : longint'({48'b0, b});
    return 32'(pa * pb);
  endfunction

  function automatic logic [47:0] ref_ext(input logic [31:0] p, input bit sgn);
    longint v;
    v = sgn ? longint'($signed(p)) : longint'({32'b0, p});
    return 48'(v);
  endfunction

  function automatic void ref_step(input bit g, input logic [15:0] a, input logic [15:0] b,
                                   input logic [2:0] op, input bit c);
    bit          sgn;
    logic [31:0] p;
    logic [47:0] e;
    if (c) begin
      exp_acc = '0;
      return;
    end
    if (!g || op == 3'd7) return;
    sgn = (op >= 3'd3);
    p = ref_prod(a, b, sgn);
    e = ref_ext(p, sgn);
    exp_prod = p;
    case (op)
      3'd0, 3'd3: exp_acc = e;
      3'd4:       exp_acc = 48'd0 - e;
      3'd1, 3'd5: exp_acc = exp_acc + e;
      default:    exp_acc = exp_acc - e;
    endcase
  endfunction

  task automatic check(input string tag);
    total++;
    if (acc_q !== exp_acc) begin
      bad++;
      $display("FAIL %s acc_q actual=%h expected=%h", tag, acc_q, exp_acc);
    end
    total++;
    if (prod_q !== exp_prod) begin
      bad++;
      $display("FAIL %s prod_q actual=%h expected=%h", tag, prod_q, exp_prod);
    end
  endtask

  // called at a falling edge; result checked at the following falling edge
  task automatic step(input bit g, input logic [15:0] a, input logic [15:0] b,
                      input logic [2:0] op, input bit c, input string tag);
    go = g; opnd_a = a; opnd_b = b; op_sel = op; acc_clr = c;
    ref_step(g, a, b, op, c);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    step(1, 16'hFFFF, 16'hFFFF, 3'd0, 0, "R2 umul max");
    step(1, 16'h0003, 16'h0005, 3'd1, 0, "R3 umac");
    step(1, 16'h1234, 16'h0010, 3'd2, 0, "R4 umsub");
    step(1, 16'h8000, 16'h8000, 3'd3, 0, "R5 smul min*min");
    step(1, 16'hFFFF, 16'h0001, 3'd3, 0, "R5 smul -1*1");
    step(1, 16'hFFFF, 16'h0002, 3'd4, 0, "R6 sneg negative");
    step(1, 16'h7FFF, 16'h7FFF, 3'd4, 0, "R6 sneg positive");
    step(1, 16'h8000, 16'h7FFF, 3'd5, 0, "R7 smac");
    step(1, 16'hFFFE, 16'h0003, 3'd6, 0, "R8 smsub");
    step(1, 16'h1111, 16'h2222, 3'd7, 0, "R9 nop");
    step(0, 16'h4321, 16'h0F0F, 3'd0, 0, "R11 idle");
    step(1, 16'hABCD, 16'h1234, 3'd0, 1, "R10 clear beats go");
    step(1, 16'h0001, 16'h0001, 3'd2, 0, "R12 wrap below zero");
    step(1, 16'h0001, 16'h0001, 3'd1, 0, "R12 wrap to zero");
    step(0, 16'h0000, 16'h0000, 3'd0, 1, "R10 clear alone");
    step(1, 16'h0002, 16'h0003, 3'd0, 0, "R13 back-to-back 1");
    step(1, 16'h0004, 16'h0005, 3'd1, 0, "R13 back-to-back 2");
    step(1, 16'hFFFF, 16'hFFFF, 3'd5, 0, "R13 back-to-back 3");

    void'($urandom(32'd7331));
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      bit g, c;
      op = 3'($urandom_range(0, 7));
      g  = ($urandom_range(0, 3) != 0);
      c  = ($urandom_range(0, 7) == 0);
      step(g, 16'($urandom), 16'($urandom), op, c,
           c ? (g ? "R10 random clear+go" : "R10 random clear") :
           (!g ? "R11 random idle" : (op == 3'd7 ? "R9 random nop" : "R13 random op")));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule